// File: doc/BRIEF.md
# Pipelined Synchronous Dual-Port RAM

This block models a synchronous static RAM with two fully independent access ports over one shared storage array. On every rising clock edge each port registers its address, write data and control lines. A port then either writes the registered data into the array in the following cycle, or reads the array in that cycle and presents the word on an output register one cycle later. Read data therefore leaves the port two clock edges after the request is captured.

Each port has a pair of chip selects of opposite polarity, so that two devices can share an address bus and the top address bit can choose between them with no extra gates. Deselecting a port for a single cycle puts its output drivers to sleep. The port must then see two selected edges in a row before it drives again. A per-port address counter supports burst access: it can be loaded from the address bus, advanced by one, or cleared. An output enable gates the drivers directly, without reference to the clock. Writes have a separate enable for each byte lane of the word.

Top module: `dual_port_pipe_ram`

## Requirements
- R1: In reset both data outputs float ('z). After reset is released, an output stays floating after the first selected edge and drives after the second.
- R2: A port is selected only when `x_cs_n`=0 and `x_cs`=1. With (1,1), (0,0) or (1,0) the port floats its output on the next cycle, ignores the write and all counter controls, and its counter keeps its value.
- R3: An edge at which a port is deselected makes that port's output float right after that edge.
- R4: After a deselect, the output still floats after the first selected edge. It drives the held output register after the second consecutive selected edge.
- R5: When `x_oe_n` is 1 the output floats at once, with no clock edge needed. When it returns to 0 the output drives again.
- R6: A read captured at edge k shows on `x_dout` after edge k+2. The output register changes only when a new read completes.
- R7: `x_lane_en[0]` writes bits [8:0] and `x_lane_en[1]` writes bits [17:9]. A lane that is not enabled keeps its old contents.
- R8: The access address is the value the counter takes at the capture edge. Priority is clear (`x_clr`, to 0), then load (`x_load`, from `x_addr`), then step (`x_step`, +1). With none of them asserted the counter holds.
- R9: A read by one port at the same edge as the other port's write to the same address returns the old word. A read one cycle later returns the new word.
- R10: When both ports write the same address and lane at the same edge, port A's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_cs | input | 1 | Port A chip select, active high |
| a_we_n | input | 1 | Port A: 0 = write, 1 = read |
| a_lane_en | input | 2 | Port A byte-lane write enables |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_load | input | 1 | Port A: load counter from address bus |
| a_step | input | 1 | Port A: advance counter by one |
| a_clr | input | 1 | Port A: clear counter |
| a_addr | input | 6 | Port A address bus |
| a_din | input | 18 | Port A write data |
| a_dout | output | 18 | Port A read data, 'z when not driving |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_cs | input | 1 | Port B chip select, active high |
| b_we_n | input | 1 | Port B: 0 = write, 1 = read |
| b_lane_en | input | 2 | Port B byte-lane write enables |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_load | input | 1 | Port B: load counter from address bus |
| b_step | input | 1 | Port B: advance counter by one |
| b_clr | input | 1 | Port B: clear counter |
| b_addr | input | 6 | Port B address bus |
| b_din | input | 18 | Port B write data |
| b_dout | output | 18 | Port B read data, 'z when not driving |

## Verification
Properties check on every cycle that a deselected edge turns the drivers off, that one selected edge after a deselect is not enough to turn them on while two are, and that a deselected port issues no access and keeps its counter. They also check that clear wins over the other counter controls, that a step adds exactly one, and that the read register holds whenever no read completes. Only the bench scenarios can show the data itself. These cover the exact two-edge read latency, byte-lane merging, old data on a same-edge collision, port A winning a write tie, counter bursts with mixed controls, and output enable acting between clock edges.

// File: rtl/dpr_pkg.sv
// Package: shared types and helpers for the dual-port pipelined RAM.
// Assumes: nothing; contains no state.
package dpr_pkg;

    // Kind of access a port registered at the last edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } acc_op_e;

    // A port is live only with the low-active select low and the high-active select high.
    function automatic logic chip_on(input logic cs_n, input logic cs);
        return (!cs_n) && cs;
    endfunction

endpackage

// File: rtl/dpr_addr_ctr.sv
// Module: per-port burst address counter.
// Computes the address used by the access being captured at this edge:
// clear beats load, load beats step, otherwise hold. When the port is not
// selected, every control is ignored and the counter holds.
// Assumes: synchronous active-low reset; the counter wraps at the top of the array.
module dpr_addr_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_next,
    output logic [ADDR_W-1:0] cnt
);

    // Pick the next counter value by priority.
    always_comb begin
        if (!en)       addr_next = cnt;
        else if (clr)  addr_next = '0;
        else if (load) addr_next = addr_in;
        else if (step) addr_next = cnt + 1'b1;
        else           addr_next = cnt;
    end

    // Hold the counter between edges.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= addr_next;
    end

    // R8: clear has top priority
    p_clr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (cnt == '0));

    // R8: a lone step adds exactly one
    p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !load && step) |=> (cnt == $past(cnt) + 1'b1));

    // R2: a deselected port keeps its counter
    p_hold_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(cnt));

endmodule

// File: rtl/dpr_port_stage.sv
// Module: input capture, select history and output register of one port.
// Registers the access kind, address, lane enables and write data at each
// edge, keeps a two-edge history of the chip select, and holds the output
// register fed by the array's read register.
// Assumes: the array read register updates one edge after capture, so the
// output register shows a read two edges after capture.
module dpr_port_stage #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   cs,
    input  logic                   we_n,
    input  logic [LANES-1:0]       lane_en,
    input  logic [DATA_W-1:0]      din,
    input  logic [ADDR_W-1:0]      addr_next,
    input  logic [DATA_W-1:0]      rd_data,
    output logic                   sel,
    output dpr_pkg::acc_op_e       op,
    output logic [ADDR_W-1:0]      acc_addr,
    output logic [LANES-1:0]       acc_lane,
    output logic [DATA_W-1:0]      acc_data,
    output logic [DATA_W-1:0]      out_q,
    output logic                   drv_ok
);
    import dpr_pkg::*;

    logic [1:0] sel_h;

    // Decode the two chip selects into one live flag.
    assign sel = chip_on(cs_n, cs);

    // Capture the access presented at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op       <= OP_IDLE;
            acc_addr <= '0;
            acc_lane <= '0;
            acc_data <= '0;
        end else begin
            op       <= !sel ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
            acc_addr <= addr_next;
            acc_lane <= lane_en;
            acc_data <= din;
        end
    end

    // Remember the select seen at the last two edges.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_h <= 2'b00;
        else        sel_h <= {sel_h[0], sel};
    end

    // Drivers wake only after two selected edges in a row.
    assign drv_ok = &sel_h;

    // Output register follows the array read register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= rd_data;
    end

    // R3: one deselected edge turns the drivers off
    p_float_after_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> (!drv_ok));

    // R4: a single selected edge after a deselect is not enough
    p_one_select_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel ##1 sel) |=> (!drv_ok));

    // R4: two selected edges in a row wake the drivers
    p_two_selects_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel ##1 sel) |=> drv_ok);

    // R2: a deselected edge issues no access
    p_no_access_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> (op == OP_IDLE));

endmodule

// File: rtl/dpr_array.sv
// Module: shared storage, split into one bank per byte lane.
// Performs the writes registered by each port and loads each port's read
// register. Reads see the contents before any write at the same edge.
// When both ports write one lane of one address, port A's data is kept.
// Assumes: storage is not reset; only the read registers are.
module dpr_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  dpr_pkg::acc_op_e       op_a,
    input  logic [ADDR_W-1:0]      addr_a,
    input  logic [LANES-1:0]       lane_a,
    input  logic [DATA_W-1:0]      data_a,
    input  dpr_pkg::acc_op_e       op_b,
    input  logic [ADDR_W-1:0]      addr_b,
    input  logic [LANES-1:0]       lane_b,
    input  logic [DATA_W-1:0]      data_b,
    output logic [DATA_W-1:0]      rd_a,
    output logic [DATA_W-1:0]      rd_b
);
    import dpr_pkg::*;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] q_a;
        logic [LANE_W-1:0] q_b;

        // Write this lane; port A is applied last so it wins a tie.
        always_ff @(posedge clk) begin
            if (op_b == OP_WRITE && lane_b[l]) bank[addr_b] <= data_b[l*LANE_W +: LANE_W];
            if (op_a == OP_WRITE && lane_a[l]) bank[addr_a] <= data_a[l*LANE_W +: LANE_W];
        end

        // Load each port's read register with the pre-write contents.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_a <= '0;
                q_b <= '0;
            end else begin
                if (op_a == OP_READ) q_a <= bank[addr_a];
                if (op_b == OP_READ) q_b <= bank[addr_b];
            end
        end

        assign rd_a[l*LANE_W +: LANE_W] = q_a;
        assign rd_b[l*LANE_W +: LANE_W] = q_b;
    end

    // R6: the read register of port A holds unless a read completes
    p_rd_hold_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a != OP_READ) |=> $stable(rd_a));

    // R6: the read register of port B holds unless a read completes
    p_rd_hold_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_b != OP_READ) |=> $stable(rd_b));

endmodule

// File: rtl/dual_port_pipe_ram.sv
// Module: top of the pipelined dual-port RAM.
// Wires two port stages and two address counters to one shared array, and
// applies the asynchronous output enable to each port's drivers.
// Assumes: one clock for both ports; synchronous active-low reset.
module dual_port_pipe_ram #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs_n,
    input  logic              a_cs,
    input  logic              a_we_n,
    input  logic [LANES-1:0]  a_lane_en,
    input  logic              a_oe_n,
    input  logic              a_load,
    input  logic              a_step,
    input  logic              a_clr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    input  logic              b_cs_n,
    input  logic              b_cs,
    input  logic              b_we_n,
    input  logic [LANES-1:0]  b_lane_en,
    input  logic              b_oe_n,
    input  logic              b_load,
    input  logic              b_step,
    input  logic              b_clr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout
);
    import dpr_pkg::*;

    logic              a_sel, b_sel;
    logic [ADDR_W-1:0] a_next, b_next, a_cnt, b_cnt;
    acc_op_e           a_op, b_op;
    logic [ADDR_W-1:0] a_acc_addr, b_acc_addr;
    logic [LANES-1:0]  a_acc_lane, b_acc_lane;
    logic [DATA_W-1:0] a_acc_data, b_acc_data;
    logic [DATA_W-1:0] a_rd, b_rd, a_q, b_q;
    logic              a_drv, b_drv;

    dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr_a (
        .clk(clk), .rst_n(rst_n), .en(a_sel), .clr(a_clr), .load(a_load),
        .step(a_step), .addr_in(a_addr), .addr_next(a_next), .cnt(a_cnt)
    );

    dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr_b (
        .clk(clk), .rst_n(rst_n), .en(b_sel), .clr(b_clr), .load(b_load),
        .step(b_step), .addr_in(b_addr), .addr_next(b_next), .cnt(b_cnt)
    );

    dpr_port_stage #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_port_a (
        .clk(clk), .rst_n(rst_n), .cs_n(a_cs_n), .cs(a_cs), .we_n(a_we_n),
        .lane_en(a_lane_en), .din(a_din), .addr_next(a_next), .rd_data(a_rd),
        .sel(a_sel), .op(a_op), .acc_addr(a_acc_addr), .acc_lane(a_acc_lane),
        .acc_data(a_acc_data), .out_q(a_q), .drv_ok(a_drv)
    );

    dpr_port_stage #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_port_b (
        .clk(clk), .rst_n(rst_n), .cs_n(b_cs_n), .cs(b_cs), .we_n(b_we_n),
        .lane_en(b_lane_en), .din(b_din), .addr_next(b_next), .rd_data(b_rd),
        .sel(b_sel), .op(b_op), .acc_addr(b_acc_addr), .acc_lane(b_acc_lane),
        .acc_data(b_acc_data), .out_q(b_q), .drv_ok(b_drv)
    );

    dpr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk(clk), .rst_n(rst_n),
        .op_a(a_op), .addr_a(a_acc_addr), .lane_a(a_acc_lane), .data_a(a_acc_data),
        .op_b(b_op), .addr_b(b_acc_addr), .lane_b(b_acc_lane), .data_b(b_acc_data),
        .rd_a(a_rd), .rd_b(b_rd)
    );

    // Output drivers: woken by select history, gated at once by output enable.
    assign a_dout = (a_drv && !a_oe_n) ? a_q : {DATA_W{1'bz}};
    assign b_dout = (b_drv && !b_oe_n) ? b_q : {DATA_W{1'bz}};

    // R1: in reset neither port drives
    p_float_in_reset_r1: assert property (@(posedge clk)
        (!rst_n) |=> (!a_drv && !b_drv));

endmodule

// File: tb/dual_port_pipe_ram_bench.sv
// Bench: directed scenarios for the pipelined dual-port RAM, one task each.
// Inputs change on the falling edge; outputs are sampled on the falling edge.
// A 10-unit clock period stands for 100 MHz with a 1 ns time unit.
module dual_port_pipe_ram_bench;

    localparam int AW = 6;
    localparam int DW = 18;
    localparam logic [DW-1:0] ZV = {DW{1'bz}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_cs_n, a_cs, a_we_n, a_oe_n, a_load, a_step, a_clr;
    logic b_cs_n, b_cs, b_we_n, b_oe_n, b_load, b_step, b_clr;
    logic [1:0]    a_lane_en, b_lane_en;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_din, b_din, a_dout, b_dout;

    logic [DW-1:0] model [64];
    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    dual_port_pipe_ram u_dual_port_pipe_ram (
        .clk(clk), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_cs(a_cs), .a_we_n(a_we_n), .a_lane_en(a_lane_en),
        .a_oe_n(a_oe_n), .a_load(a_load), .a_step(a_step), .a_clr(a_clr),
        .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
        .b_cs_n(b_cs_n), .b_cs(b_cs), .b_we_n(b_we_n), .b_lane_en(b_lane_en),
        .b_oe_n(b_oe_n), .b_load(b_load), .b_step(b_step), .b_clr(b_clr),
        .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_driven(input string req, input logic [DW-1:0] act);
        n_checks++;
        if ((^act) === 1'bx) begin
            n_fails++;
            $display("FAIL %s: actual %h expected a driven value", req, act);
        end
    endtask

    task automatic drv_a(input logic cs_n, input logic cs, input logic we_n, input logic [1:0] ln,
                         input logic ld, input logic st, input logic cl,
                         input logic [AW-1:0] ad, input logic [DW-1:0] d);
        a_cs_n = cs_n; a_cs = cs; a_we_n = we_n; a_lane_en = ln;
        a_load = ld; a_step = st; a_clr = cl; a_addr = ad; a_din = d;
    endtask

    task automatic drv_b(input logic cs_n, input logic cs, input logic we_n, input logic [1:0] ln,
                         input logic ld, input logic st, input logic cl,
                         input logic [AW-1:0] ad, input logic [DW-1:0] d);
        b_cs_n = cs_n; b_cs = cs; b_we_n = we_n; b_lane_en = ln;
        b_load = ld; b_step = st; b_clr = cl; b_addr = ad; b_din = d;
    endtask

    task automatic merge(input logic [AW-1:0] ad, input logic [DW-1:0] d, input logic [1:0] ln);
        if (ln[0]) model[ad][8:0]  = d[8:0];
        if (ln[1]) model[ad][17:9] = d[17:9];
    endtask

    task automatic a_read(input logic [AW-1:0] ad, input logic ld);
        drv_a(1'b0, 1'b1, 1'b1, 2'b00, ld, 1'b0, 1'b0, ad, '0);
    endtask

    task automatic b_read(input logic [AW-1:0] ad, input logic ld);
        drv_b(1'b0, 1'b1, 1'b1, 2'b00, ld, 1'b0, 1'b0, ad, '0);
    endtask

    task automatic a_write(input logic [AW-1:0] ad, input logic [DW-1:0] d, input logic [1:0] ln);
        drv_a(1'b0, 1'b1, 1'b0, ln, 1'b1, 1'b0, 1'b0, ad, d);
        merge(ad, d, ln);
    endtask

    // R1: float in reset, one selected edge still floats, two drive
    task automatic t_reset();
        a_oe_n = 1'b0; b_oe_n = 1'b0;
        a_read(6'd0, 1'b1); b_read(6'd0, 1'b1);
        rst_n = 1'b0;
        repeat (3) tick();
        check("R1 a float in reset", a_dout, ZV);
        check("R1 b float in reset", b_dout, ZV);
        rst_n = 1'b1;
        tick();
        check("R1 a float after one edge", a_dout, ZV);
        check("R1 b float after one edge", b_dout, ZV);
        tick();
        check("R1 a drives after two edges", a_dout, '0);
        check("R1 b drives after two edges", b_dout, '0);
    endtask

    // R8: fill every word with a counter burst (load then step)
    task automatic t_fill();
        for (int i = 0; i < 64; i++) begin
            drv_a(1'b0, 1'b1, 1'b0, 2'b11, i == 0, i != 0, 1'b0, '0, DW'(i * 1031 + 7));
            model[i] = DW'(i * 1031 + 7);
            tick();
        end
        a_read(6'd7, 1'b1);
        repeat (3) tick();
    endtask

    // R6: exact two-edge read latency
    task automatic t_latency();
        a_read(6'd5, 1'b1);
        tick();
        tick();
        check("R6 old word one edge after capture", a_dout, model[7]);
        tick();
        check("R6 new word two edges after capture", a_dout, model[5]);
    endtask

    // R7: byte-lane writes merge into the stored word
    task automatic t_lanes();
        a_write(6'd9, 18'h3FFFF, 2'b01); tick();
        a_write(6'd9, 18'h00000, 2'b10); tick();
        a_write(6'd9, 18'h3FFFF, 2'b00); tick();
        a_read(6'd9, 1'b1);
        repeat (3) tick();
        check("R7 lanes merged", a_dout, 18'h001FF);
    endtask

    // R3 and R4: deselect floats, two selected edges re-drive
    task automatic t_reactivate();
        a_read(6'd7, 1'b1);
        repeat (3) tick();
        drv_a(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, '0, '0);
        tick();
        check("R3 float after deselect", a_dout, ZV);
        a_read(6'd0, 1'b0);
        tick();
        check("R4 float after one selected edge", a_dout, ZV);
        tick();
        check("R4 drives after two selected edges", a_dout, model[7]);
    endtask

    // R5: output enable acts between clock edges
    task automatic t_oe();
        #1 a_oe_n = 1'b1;
        #1 check("R5 float with oe high", a_dout, ZV);
        a_oe_n = 1'b0;
        #1 check("R5 drive with oe low", a_dout, model[7]);
        tick();
    endtask

    // R2: each non-selecting combination ignores write and counter controls
    task automatic t_select(input logic cs_n, input logic cs);
        a_read(6'd40, 1'b1);
        repeat (3) tick();
        drv_a(cs_n, cs, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 6'd30, 18'h2AAAA);
        tick();
        check("R2 float when deselected", a_dout, ZV);
        a_read(6'd0, 1'b0);
        repeat (3) tick();
        check("R2 counter held while deselected", a_dout, model[40]);
        a_read(6'd30, 1'b1);
        repeat (3) tick();
        check("R2 write ignored while deselected", a_dout, model[30]);
    endtask

    // R8: counter priority clear > load > step, hold with none
    task automatic t_counter();
        logic [AW-1:0] exp [7] = '{6'd10, 6'd11, 6'd12, 6'd0, 6'd20, 6'd20, 6'd21};
        logic [2:0]    ctl [7] = '{3'b100, 3'b010, 3'b010, 3'b111, 3'b110, 3'b000, 3'b010};
        for (int k = 0; k < 10; k++) begin
            if (k >= 3) check("R8 counter burst address", a_dout, model[exp[k-3]]);
            if (k < 7) drv_a(1'b0, 1'b1, 1'b1, 2'b00, ctl[k][2], ctl[k][1], ctl[k][0], k < 3 ? 6'd10 : 6'd20, '0);
            else       a_read(6'd0, 1'b0);
            tick();
        end
    endtask

    // R9 and R10: same-edge collisions between the ports
    task automatic t_collide();
        logic [DW-1:0] old_w;
        a_read(6'd50, 1'b1); b_read(6'd50, 1'b1);
        repeat (3) tick();
        old_w = model[50];
        a_write(6'd50, 18'h12345, 2'b11);
        tick();
        a_read(6'd50, 1'b1);
        tick();
        tick();
        check("R9 same-edge read gets old word", b_dout, old_w);
        tick();
        check("R9 later read gets new word", b_dout, 18'h12345);
        a_write(6'd51, 18'h0AAAA, 2'b11);
        drv_b(1'b0, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 6'd51, 18'h15555);
        tick();
        a_read(6'd51, 1'b1); b_read(6'd51, 1'b1);
        repeat (3) tick();
        check("R10 port A wins write tie (A view)", a_dout, 18'h0AAAA);
        check("R10 port A wins write tie (B view)", b_dout, 18'h0AAAA);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_latency();
        t_lanes();
        t_reactivate();
        t_oe();
        t_select(1'b1, 1'b1);
        t_select(1'b0, 1'b0);
        t_select(1'b1, 1'b0);
        t_counter();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule